// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects up to 31 active-high interrupt request lines, numbered 1 to 31, and presents a single interrupt request plus a 5-bit vector to a processor core. Each line is configured by software as level-sensitive or edge-triggered. Edge lines are caught in a per-source latch that software drops through a write-one-to-clear register. Level lines show their input directly.

Each source has its own enable bit. The request output is raised whenever some enabled source is pending. The vector names the winning source, which is the enabled pending source with the lowest number. Number 0 is reserved and appears on the vector only when nothing is requesting. Software can poll pending status through a status register whether or not a source is enabled. When the core acknowledges, the vector is captured into a holding register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable, mode and latch state are all zero, `irq` is low, `irq_vec` is 0 and `ack_vec` is 0.
- R2: Bit 0 of every register reads as 0. Source 0 does not exist, and `irq_vec` is 0 exactly when `irq` is low.
- R3: Address 0 is the enable register and address 1 is the mode register (1 = edge, 0 = level). Both are read/write on bits 31:1, where bit n belongs to source n.
- R4: An edge source latches when its input is high in a cycle after being low in the previous cycle. The latch holds after the input falls. It is dropped by writing 1 to bit n at address 3. If a new edge arrives in the same cycle as the clear, the latch stays set.
- R5: A level source's pending bit equals its input, and writing its clear bit has no effect.
- R6: Address 2 reads the pending bits of all sources, enabled or not. A pending source whose enable bit is 0 does not raise `irq`.
- R7: `irq` is high when any source is both enabled and pending. `irq_vec` then gives the lowest-numbered such source, combinationally.
- R8: In a cycle where `irq_ack` is high, `irq_vec` is captured into `ack_vec` at the clock edge. `ack_vec` holds its value otherwise.
- R9: Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 31 | Request lines, bit n = source n (n = 1..31) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 31 | Write data for bits 31:1 |
| reg_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Interrupt request to the core |
| irq_vec | output | 5 | Number of the winning source, 0 when idle |
| irq_ack | input | 1 | Core acknowledge |
| ack_vec | output | 5 | Vector captured at the last acknowledge |

## Verification
The vector is first tried with every single source raised on its own, which separates a wrong encoder bit from a correct one. It is then tried with every pair of sources raised, which shows whether the lower number really wins. Next, all inputs are held high while the enable mask is narrowed one source at a time; this tells an enable-gated winner apart from one taken from the raw inputs. Each source is also given a one-cycle pulse in edge mode and then cleared, which separates latching from following the input. Separate cases cover a clear that coincides with a new edge, and a clear written to a level source, where the two latch policies differ.

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl #(
  parameter int NSRC = 31,
  localparam int VW = $clog2(NSRC + 1),
  localparam int DW = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC:1]   src_req,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC:1]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  output logic [VW-1:0]   irq_vec,
  input  logic            irq_ack,
  output logic [VW-1:0]   ack_vec
);

  logic [NSRC:1] en_q, mode_q, lat_q, prev_q;
  logic [NSRC:1] mode_d, clr, edge_hit, pend, act;

  assign mode_d   = (reg_wr && reg_addr == 2'd1) ? reg_wdata : mode_q;
  assign clr      = (reg_wr && reg_addr == 2'd3) ? reg_wdata : '0;
  assign edge_hit = src_req & ~prev_q & mode_q;
  assign pend     = (mode_q & lat_q) | (~mode_q & src_req);
  assign act      = pend & en_q;
  assign irq      = |act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      mode_q  <= '0;
      lat_q   <= '0;
      prev_q  <= '0;
      ack_vec <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd0) en_q <= reg_wdata;
      mode_q <= mode_d;
      lat_q  <= ((lat_q & ~clr) | edge_hit) & mode_d;
      prev_q <= src_req;
      if (irq_ack) ack_vec <= irq_vec;
    end
  end

  always_comb begin
    irq_vec = '0;
    for (int i = NSRC; i >= 1; i--)
      if (act[i]) irq_vec = VW'(i);
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {en_q, 1'b0};
      2'd1:    reg_rdata = {mode_q, 1'b0};
      2'd2:    reg_rdata = {pend, 1'b0};
      default: reg_rdata = '0;
    endcase
  end

  logic [DW-1:0] act0;
  assign act0 = {act, 1'b0};

  a_r2_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> irq_vec == '0);
  a_r7_winner_active: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_vec != '0 && act0[irq_vec]));
  a_r7_no_lower_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((act0 & ((DW'(1) << irq_vec) - DW'(1))) == '0));
  a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd3) |=> ((lat_q & $past(reg_wdata) & ~$past(edge_hit)) == '0));
  a_r5_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q & ~mode_q) == '0);
  a_r8_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> ack_vec == $past(irq_vec));
  a_r8_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ack |=> $stable(ack_vec));

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic clk = 0, rst_n = 0;
  logic [31:0] sv = '0;
  logic reg_wr = 0, irq_ack = 0;
  logic [1:0] reg_addr = '0;
  logic [31:1] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  logic [4:0] irq_vec, ack_vec;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(sv[31:1]), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .irq_vec(irq_vec), .irq_ack(irq_ack), .ack_vec(ack_vec));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d[31:1];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d == 0, "R1 reset reg", d, 0);
    end
    chk(irq == 0 && irq_vec == 0 && ack_vec == 0, "R1 reset outputs", {irq, irq_vec, ack_vec}, 0);

    // R3 / R2 readback, bit 0 reads 0
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d); chk(d == 32'hFFFF_FFFE, "R3 R2 enable readback", d, 32'hFFFF_FFFE);
    wr(2'd1, 32'hA5A5_5A5B);
    rd(2'd1, d); chk(d == 32'hA5A5_5A5A, "R3 R2 mode readback", d, 32'hA5A5_5A5A);
    wr(2'd1, 32'h0);
    rd(2'd3, d); chk(d == 0, "R9 clear reads zero", d, 0);

    // R7 single level sources
    for (int i = 1; i < 32; i++) begin
      sv = 32'd1 << i; #0.5;
      chk(irq == 1 && irq_vec == i, "R7 single source vector", irq_vec, i);
      rd(2'd2, d); chk(d == sv, "R5 level status follows input", d, sv);
    end
    sv = '0; #0.5;
    chk(irq == 0 && irq_vec == 0, "R2 idle vector zero", irq_vec, 0);

    // R7 every pair: lower number wins
    for (int i = 1; i < 32; i++)
      for (int j = i + 1; j < 32; j++) begin
        sv = (32'd1 << i) | (32'd1 << j); #0.5;
        chk(irq_vec == i, "R7 pair priority", irq_vec, i);
      end

    // R6 / R7 enable mask sweep with all inputs high
    sv = 32'hFFFF_FFFE;
    for (int k = 1; k < 32; k++) begin
      wr(2'd0, ~((32'd1 << k) - 1) & 32'hFFFF_FFFE);
      #0.5;
      chk(irq == 1 && irq_vec == k, "R7 enable gated winner", irq_vec, k);
    end
    wr(2'd0, 32'h0);
    #0.5;
    chk(irq == 0 && irq_vec == 0, "R6 disabled no irq", {irq, irq_vec}, 0);
    rd(2'd2, d); chk(d == 32'hFFFF_FFFE, "R6 status while disabled", d, 32'hFFFF_FFFE);

    // R5 level clear has no effect
    wr(2'd0, 32'hFFFF_FFFE);
    sv = 32'd1 << 3;
    wr(2'd3, 32'd1 << 3);
    rd(2'd2, d); chk(d == (32'd1 << 3), "R5 level clear ignored", d, 32'd1 << 3);

    // R4 edge sweep
    sv = '0;
    wr(2'd1, 32'hFFFF_FFFE);
    @(negedge clk);
    for (int i = 1; i < 32; i++) begin
      sv = 32'd1 << i;
      @(negedge clk); sv = '0;
      @(negedge clk);
      rd(2'd2, d);
      chk(d == (32'd1 << i) && irq_vec == i, "R4 edge latched after input fell", d, 32'd1 << i);
      wr(2'd3, 32'd1 << i);
      rd(2'd2, d); chk(d == 0, "R4 edge cleared", d, 0);
    end

    // R4 clear with simultaneous new edge keeps latch
    sv = 32'd1 << 7;
    @(negedge clk); sv = '0;
    @(negedge clk);
    sv = 32'd1 << 7; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 31'd1 << 6;
    @(negedge clk); reg_wr = 0;
    rd(2'd2, d); chk(d == (32'd1 << 7), "R4 edge wins over clear", d, 32'd1 << 7);
    wr(2'd3, 32'd1 << 7);
    rd(2'd2, d); chk(d == 0, "R4 held high no re-latch", d, 0);
    sv = '0;

    // R8 acknowledge capture
    wr(2'd1, 32'h0);
    sv = (32'd1 << 9) | (32'd1 << 20);
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk(ack_vec == 9, "R8 ack captured", ack_vec, 9);
    sv = 32'd1 << 20;
    @(negedge clk); #0.5;
    chk(ack_vec == 9 && irq_vec == 20, "R8 ack holds", ack_vec, 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule